// File: doc/BRIEF.md
# Single-Channel Byte Mover with Bus Request/Grant

This block copies a run of bytes between a peripheral byte port and main memory without the processor touching each byte. The processor loads a start address and a byte count through a small register window and then writes a command word that names the direction and starts the job. From then on the engine asks for the memory bus with a request line. It touches memory only while the processor's grant line is high. The processor keeps the right to deny or take back the bus on any cycle.

Every byte passes through one internal staging register. A fetch cycle loads it from the source and a store cycle empties it into the destination. After each store the address moves up by one and the remaining count moves down by one. When the count runs out, the request drops, a sticky done flag is set and a one-cycle interrupt pulse is produced. A job started with a count of zero finishes on the next cycle and never asks for the bus.

Top module: `dma_engine`

## Requirements
- R1: After reset, `bus_req`, `busy`, `done` and `irq` are all low and every memory and device strobe is idle.
- R2: Register window, selected by `reg_sel`: offset 0 is the address register and offset 1 is the length register; both read back their current value. Offset 2 is the command register. On write, bit 0 = start and bit 1 = direction (0 = device to memory, 1 = memory to device). On read it is status, with bit 0 = busy and bit 1 = done.
- R3: An accepted start with a nonzero length raises `bus_req` and `busy` on the next cycle. Both stay high until the cycle after the final byte is stored, and no memory or device strobe occurs while `bus_req` is low.
- R4: `mem_rd` and `mem_wr` are never high in a cycle where `bus_grant` is low.
- R5: In device-to-memory mode, the bytes taken from `dev_rdata` are written to memory at consecutive addresses from the start address, in arrival order.
- R6: In memory-to-device mode, the bytes read from consecutive memory addresses are presented on `dev_wdata` with `dev_wr`, in address order.
- R7: Each byte takes one granted fetch cycle and one granted store cycle. With grant held high, an N-byte job shows `done` exactly 2N cycles after the edge that accepts the command.
- R8: After each stored byte the address register increases by one and the length register decreases by one. At the end, the address reads start+N and the length reads 0.
- R9: While grant is low, the job makes no progress: address and length hold, `bus_req` stays high, and the job resumes correctly when grant returns.
- R10: On completion, `done` is set and `irq` is high for exactly one cycle, in the same cycle that `busy` and `bus_req` clear. `done` is cleared by the next accepted start with a nonzero length.
- R11: While `busy` is high, writes to any register, including a new command, are ignored.
- R12: A start with length 0 sets `done` and pulses `irq` on the next cycle, never raises `bus_req`, and leaves the address unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data for `reg_sel`, combinational |
| bus_req | output | 1 | Memory bus request |
| bus_grant | input | 1 | Memory bus grant from the processor |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rd | output | 1 | Memory read strobe, data sampled same cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| dev_rd | output | 1 | Take one byte from the device |
| dev_rdata | input | DATA_W | Device byte offered |
| dev_wr | output | 1 | Hand one byte to the device |
| dev_wdata | output | DATA_W | Byte handed to the device |
| busy | output | 1 | Job in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
Register readback is combinational, so it is due in the same cycle as the select. `bus_req` and `busy` are due one edge after the accepting edge. With continuous grant, each byte's memory or device strobe falls on the second granted cycle of its pair, and `done` with `irq` lands 2N edges after the command. A zero-length start completes one edge after it. The bench counts falling edges from the one that follows the accepting rising edge, and samples each result exactly at its due edge. Byte contents and order are matched through a scoreboard queue whenever a store strobe appears, so gaps in grant move when a byte arrives but not what it must hold.

// File: rtl/dma_pkg.sv
package dma_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_STORE = 2'd2
   } dma_state_e;

   localparam logic [1:0] OFS_ADDR = 2'd0;
   localparam logic [1:0] OFS_LEN  = 2'd1;
   localparam logic [1:0] OFS_CMD  = 2'd2;

   localparam int CMD_GO_BIT   = 0;
   localparam int CMD_DIR_BIT  = 1;
   localparam int STS_BUSY_BIT = 0;
   localparam int STS_DONE_BIT = 1;

endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
   import dma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              busy,
   input  logic              done,
   input  logic              advance,
   output logic              start_ok,
   output logic              dir,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              len_zero,
   output logic              len_last
);

   localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
   localparam logic [LEN_W-1:0]  LEN_ONE  = 1;

   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  len_q;
   logic              dir_q;
   logic [ADDR_W-1:0] len_view;
   logic [ADDR_W-1:0] status_view;
   logic              write_ok;

   assign write_ok = reg_wr && !busy;
   assign start_ok = write_ok && (reg_sel == OFS_CMD) && reg_wdata[CMD_GO_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         len_q  <= '0;
         dir_q  <= 1'b0;
      end else if (advance) begin
         addr_q <= addr_q + ADDR_ONE;
         len_q  <= len_q - LEN_ONE;
      end else if (write_ok) begin
         case (reg_sel)
            OFS_ADDR: addr_q <= reg_wdata;
            OFS_LEN:  len_q  <= reg_wdata[LEN_W-1:0];
            OFS_CMD:  if (reg_wdata[CMD_GO_BIT]) dir_q <= reg_wdata[CMD_DIR_BIT];
            default:  ;
         endcase
      end
   end

   generate
      if (LEN_W == ADDR_W) begin : g_len_full
         assign len_view = len_q;
      end else begin : g_len_pad
         assign len_view = {{(ADDR_W-LEN_W){1'b0}}, len_q};
      end
   endgenerate

   always_comb begin
      status_view               = '0;
      status_view[STS_BUSY_BIT] = busy;
      status_view[STS_DONE_BIT] = done;
   end

   always_comb begin
      case (reg_sel)
         OFS_ADDR: reg_rdata = addr_q;
         OFS_LEN:  reg_rdata = len_view;
         OFS_CMD:  reg_rdata = status_view;
         default:  reg_rdata = '0;
      endcase
   end

   assign dir      = dir_q;
   assign cur_addr = addr_q;
   assign len_zero = (len_q == '0);
   assign len_last = (len_q == LEN_ONE);

endmodule

// File: rtl/dma_sequencer.sv
module dma_sequencer
   import dma_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_ok,
   input  logic len_zero,
   input  logic len_last,
   input  logic grant,
   output logic busy,
   output logic done,
   output logic irq,
   output logic fetch_en,
   output logic store_en
);

   dma_state_e state_q;
   logic       done_q;
   logic       irq_q;

   assign busy     = (state_q != ST_IDLE);
   assign fetch_en = (state_q == ST_FETCH) && grant;
   assign store_en = (state_q == ST_STORE) && grant;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_ok) begin
                  if (len_zero) begin
                     done_q <= 1'b1;
                     irq_q  <= 1'b1;
                  end else begin
                     done_q  <= 1'b0;
                     state_q <= ST_FETCH;
                  end
               end
            end
            ST_FETCH: begin
               if (grant) state_q <= ST_STORE;
            end
            ST_STORE: begin
               if (grant) begin
                  if (len_last) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                     irq_q   <= 1'b1;
                  end else begin
                     state_q <= ST_FETCH;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign done = done_q;
   assign irq  = irq_q;

endmodule

// File: rtl/dma_datapath.sv
module dma_datapath #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_en,
   input  logic              dir,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] dev_rdata,
   output logic [DATA_W-1:0] stage_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else if (fetch_en) begin
         stage_q <= dir ? mem_rdata : dev_rdata;
      end
   end

endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 12,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   output logic              bus_req,
   input  logic              bus_grant,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              dev_rd,
   input  logic [DATA_W-1:0] dev_rdata,
   output logic              dev_wr,
   output logic [DATA_W-1:0] dev_wdata,
   output logic              busy,
   output logic              done,
   output logic              irq
);

   generate
      if (LEN_W > ADDR_W) begin : g_bad_len
         $error("dma_engine: LEN_W must not exceed ADDR_W");
      end
      if (LEN_W < 1) begin : g_bad_len_min
         $error("dma_engine: LEN_W must be at least 1");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("dma_engine: ADDR_W must hold the status bits");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("dma_engine: DATA_W must be at least 1");
      end
   endgenerate

   logic              start_ok;
   logic              dir;
   logic              len_zero;
   logic              len_last;
   logic              fetch_en;
   logic              store_en;
   logic              busy_w;
   logic              done_w;
   logic              irq_w;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] stage_q;

   dma_regfile #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .busy      (busy_w),
      .done      (done_w),
      .advance   (store_en),
      .start_ok  (start_ok),
      .dir       (dir),
      .cur_addr  (cur_addr),
      .len_zero  (len_zero),
      .len_last  (len_last)
   );

   dma_sequencer u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_ok (start_ok),
      .len_zero (len_zero),
      .len_last (len_last),
      .grant    (bus_grant),
      .busy     (busy_w),
      .done     (done_w),
      .irq      (irq_w),
      .fetch_en (fetch_en),
      .store_en (store_en)
   );

   dma_datapath #(
      .DATA_W (DATA_W)
   ) u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .fetch_en  (fetch_en),
      .dir       (dir),
      .mem_rdata (mem_rdata),
      .dev_rdata (dev_rdata),
      .stage_q   (stage_q)
   );

   assign bus_req   = busy_w;
   assign mem_addr  = cur_addr;
   assign mem_rd    = fetch_en &&  dir;
   assign dev_rd    = fetch_en && !dir;
   assign mem_wr    = store_en && !dir;
   assign dev_wr    = store_en &&  dir;
   assign mem_wdata = stage_q;
   assign dev_wdata = stage_q;
   assign busy      = busy_w;
   assign done      = done_w;
   assign irq       = irq_w;

endmodule

// File: rtl/dma_engine_checker.sv
module dma_engine_checker #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_grant,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              dev_rd,
   input logic              dev_wr,
   input logic              busy,
   input logic              done,
   input logic              irq
);

   // R4: memory is driven only under grant
   p_grant_before_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> bus_grant);

   // R3: every strobe happens while the bus is requested
   p_req_covers_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr || dev_rd || dev_wr) |-> bus_req);

   // R5: a cycle moves at most one side of one byte
   p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr, dev_rd, dev_wr}));

   // R10: the interrupt comes with done and after the request has dropped
   p_irq_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (done && !bus_req && !busy));

   // R9: a denied cycle leaves the address where it was
   p_hold_when_denied_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_grant) |=> (mem_addr == $past(mem_addr)));

   // R12: a rising done without a prior request comes from a zero-length start
   p_done_rise_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> irq);

endmodule

bind dma_engine dma_engine_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_req   (bus_req),
   .bus_grant (bus_grant),
   .mem_addr  (mem_addr),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .dev_rd    (dev_rd),
   .dev_wr    (dev_wr),
   .busy      (busy),
   .done      (done),
   .irq       (irq)
);

// File: tb/dma_engine_bench.sv
module dma_engine_bench;

   localparam int ADDR_W = 16;
   localparam int LEN_W  = 12;
   localparam int DATA_W = 8;
   localparam int ITEM_W = 1 + ADDR_W + DATA_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [1:0]        reg_sel = 2'd0;
   logic [ADDR_W-1:0] reg_wdata = '0;
   logic [ADDR_W-1:0] reg_rdata;
   logic              bus_req;
   logic              bus_grant = 1'b1;
   logic [ADDR_W-1:0] mem_addr;
   logic              mem_rd;
   logic              mem_wr;
   logic [DATA_W-1:0] mem_wdata;
   logic [DATA_W-1:0] mem_rdata;
   logic              dev_rd;
   logic [DATA_W-1:0] dev_rdata;
   logic              dev_wr;
   logic [DATA_W-1:0] dev_wdata;
   logic              busy;
   logic              done;
   logic              irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;
   int grant_mode = 0;
   logic [7:0] lfsr = 8'hA5;

   logic [ITEM_W-1:0] sb_q[$];

   logic [DATA_W-1:0] mem_arr [256];
   bit                mem_valid [256];
   logic [DATA_W-1:0] dev_src = 8'h30;

   always #10 clk = ~clk;

   dma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_dma_engine (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
      .bus_grant(bus_grant), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .dev_rd(dev_rd), .dev_rdata(dev_rdata), .dev_wr(dev_wr),
      .dev_wdata(dev_wdata), .busy(busy), .done(done), .irq(irq)
   );

   function automatic logic [DATA_W-1:0] fill_val(input logic [7:0] a);
      return a * 8'd7 + 8'd3;
   endfunction

   assign mem_rdata = mem_valid[mem_addr[7:0]] ? mem_arr[mem_addr[7:0]] : fill_val(mem_addr[7:0]);
   assign dev_rdata = dev_src;

   always @(posedge clk) begin
      if (mem_wr) begin
         mem_arr[mem_addr[7:0]]   <= mem_wdata;
         mem_valid[mem_addr[7:0]] <= 1'b1;
      end
      if (dev_rd) dev_src <= dev_src + 8'd1;
   end

   always @(negedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (grant_mode)
         0:       bus_grant <= 1'b1;
         1:       bus_grant <= lfsr[0] | lfsr[2];
         default: bus_grant <= 1'b0;
      endcase
   end

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_wr || mem_rd)
            check(bus_grant == 1'b1, "R4 strobe without grant", {31'd0, bus_grant}, 32'd1);
         if (mem_wr || dev_wr) begin
            logic [ITEM_W-1:0] got;
            got = {dev_wr, mem_addr, (dev_wr ? dev_wdata : mem_wdata)};
            if (sb_q.size() == 0) begin
               check(1'b0, "R5/R6 unexpected byte", {8'd0, got}, 32'd0);
            end else begin
               logic [ITEM_W-1:0] exp_item;
               exp_item = sb_q.pop_front();
               check(got == exp_item, dev_wr ? "R6 device byte" : "R5 memory byte",
                     {7'd0, got}, {7'd0, exp_item});
            end
         end
      end
   end

   task automatic reg_write(input logic [1:0] sel, input logic [ADDR_W-1:0] val);
      reg_sel   = sel;
      reg_wdata = val;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] sel, output logic [ADDR_W-1:0] val);
      reg_sel = sel;
      #1;
      val = reg_rdata;
   endtask

   task automatic wait_idle(input int limit);
      int n = 0;
      while (busy && n < limit) begin
         @(negedge clk);
         n++;
      end
      check(!busy, "R9 job finished", {31'd0, busy}, 32'd0);
   endtask

   task automatic push_dev_to_mem(input logic [ADDR_W-1:0] a, input int n);
      for (int i = 0; i < n; i++)
         sb_q.push_back({1'b0, a + ADDR_W'(i), dev_src + DATA_W'(i)});
   endtask

   task automatic push_mem_to_dev(input logic [ADDR_W-1:0] a, input int n);
      for (int i = 0; i < n; i++) begin
         logic [ADDR_W-1:0] aa;
         aa = a + ADDR_W'(i);
         sb_q.push_back({1'b1, aa, fill_val(aa[7:0])});
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [ADDR_W-1:0] rv;
      logic [ADDR_W-1:0] a0;
      logic [ADDR_W-1:0] l0;
      for (int i = 0; i < 256; i++) mem_valid[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(!bus_req && !busy && !done && !irq, "R1 reset outputs",
            {28'd0, bus_req, busy, done, irq}, 32'd0);
      check(!mem_rd && !mem_wr && !dev_rd && !dev_wr, "R1 idle strobes",
            {28'd0, mem_rd, mem_wr, dev_rd, dev_wr}, 32'd0);

      // T1: device to memory, 4 bytes, continuous grant
      reg_write(2'd0, 16'h0010);
      reg_write(2'd1, 16'd4);
      reg_read(2'd0, rv);
      check(rv == 16'h0010, "R2 address readback", rv, 32'h10);
      reg_read(2'd1, rv);
      check(rv == 16'd4, "R2 length readback", rv, 32'd4);
      push_dev_to_mem(16'h0010, 4);
      reg_write(2'd2, 16'h0001);
      check(bus_req && busy, "R3 request after start", {30'd0, bus_req, busy}, 32'd3);
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         if (k == 7) check(busy && bus_req, "R7 still busy at 2N-1", {30'd0, busy, bus_req}, 32'd3);
         if (k == 8) check(!busy && !bus_req && done && irq, "R7 R10 done at 2N",
                           {28'd0, busy, bus_req, done, irq}, 32'h3);
      end
      @(negedge clk);
      check(!irq && done, "R10 irq one cycle", {30'd0, irq, done}, 32'd1);
      reg_read(2'd0, rv);
      check(rv == 16'h0014, "R8 final address", rv, 32'h14);
      reg_read(2'd1, rv);
      check(rv == 16'd0, "R8 final length", rv, 32'd0);
      reg_read(2'd2, rv);
      check(rv == 16'h0002, "R2 status done", rv, 32'h2);
      check(sb_q.size() == 0, "R5 all bytes stored", sb_q.size(), 32'd0);

      // T2: memory to device, 5 bytes
      reg_write(2'd0, 16'h0040);
      reg_write(2'd1, 16'd5);
      push_mem_to_dev(16'h0040, 5);
      reg_write(2'd2, 16'h0003);
      check(!done && busy, "R10 done cleared by start", {30'd0, done, busy}, 32'd1);
      for (int k = 1; k <= 10; k++) begin
         @(negedge clk);
         if (k == 10) check(!busy && done && irq, "R7 memory-to-device timing",
                            {29'd0, busy, done, irq}, 32'd3);
      end
      check(sb_q.size() == 0, "R6 all bytes delivered", sb_q.size(), 32'd0);

      // T3: grant withdrawn partway
      reg_write(2'd0, 16'h0020);
      reg_write(2'd1, 16'd8);
      push_dev_to_mem(16'h0020, 8);
      reg_write(2'd2, 16'h0001);
      repeat (3) @(negedge clk);
      grant_mode = 2;
      repeat (2) @(negedge clk);
      reg_read(2'd0, a0);
      reg_read(2'd1, l0);
      repeat (6) @(negedge clk);
      reg_read(2'd0, rv);
      check(rv == a0, "R9 address held", rv, a0);
      reg_read(2'd1, rv);
      check(rv == l0, "R9 length held", rv, l0);
      check(bus_req && busy, "R9 request kept", {30'd0, bus_req, busy}, 32'd3);
      grant_mode = 1;
      wait_idle(1000);
      grant_mode = 0;
      reg_read(2'd0, rv);
      check(rv == 16'h0028, "R8 R9 address after pause", rv, 32'h28);
      reg_read(2'd1, rv);
      check(rv == 16'd0, "R8 R9 length after pause", rv, 32'd0);
      check(sb_q.size() == 0, "R9 bytes intact", sb_q.size(), 32'd0);
      @(negedge clk);

      // T4: writes while busy are ignored
      reg_write(2'd0, 16'h0080);
      reg_write(2'd1, 16'd6);
      push_dev_to_mem(16'h0080, 6);
      reg_write(2'd2, 16'h0001);
      reg_write(2'd0, 16'h0000);
      reg_write(2'd1, 16'd9);
      reg_write(2'd2, 16'h0003);
      wait_idle(200);
      reg_read(2'd0, rv);
      check(rv == 16'h0086, "R11 address write ignored", rv, 32'h86);
      reg_read(2'd1, rv);
      check(rv == 16'd0, "R11 length write ignored", rv, 32'd0);
      repeat (3) @(negedge clk);
      check(!busy && !bus_req, "R11 command ignored", {30'd0, busy, bus_req}, 32'd0);
      check(sb_q.size() == 0, "R11 bytes to original target", sb_q.size(), 32'd0);

      // T5: zero length
      reg_write(2'd1, 16'd0);
      reg_write(2'd2, 16'h0001);
      check(done && irq && !busy && !bus_req, "R12 immediate completion",
            {28'd0, done, irq, busy, bus_req}, 32'hC);
      @(negedge clk);
      check(!irq && !bus_req, "R12 no request", {30'd0, irq, bus_req}, 32'd0);
      reg_read(2'd0, rv);
      check(rv == 16'h0086, "R12 address unchanged", rv, 32'h86);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule